// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block sits beside a single-cycle 32-bit datapath. It turns each fetched instruction word into that cycle's control vector, with no state of its own. From the primary opcode (bits 31:26), the function field of register-form instructions (bits 5:0), the ALU zero flag, a reset request and an interrupt request, it computes the following:

- the next-PC source
- the register-file write-address source
- the two ALU operand sources
- the register write-data source
- the ALU function
- the two write enables

Two operands are specific to this datapath. Operand A can be a register, the 5-bit shift-amount field (bits 10:6) or the constant 16, which builds load-upper-immediate from the left shifter. Operand B is a register or the sign-extended 16-bit immediate. Any opcode or function code outside the supported set is steered to an illegal-instruction trap. The trap saves the return address in register 27 and can never write memory. An interrupt does the same with its own vector. A reset request overrides everything and performs no writes.

Top module: `ctl_decode`

## Requirements

Output encodings:

- pc_src: 0 = PC+4, 1 = branch target, 2 = jump target, 3 = register, 4 = illegal trap, 5 = interrupt, 6 = reset.
- wa_sel: 0 = rd, 1 = rt, 2 = r31, 3 = r27.
- a_sel: 0 = register, 1 = shamt, 2 = constant 16.
- b_sel: 0 = register, 1 = sign-extended immediate.
- wd_sel: 0 = PC+4, 1 = ALU, 2 = memory.
- alu_fn: ADD = 0, SUB = 1, AND = 2, OR = 3, XOR = 4, NOR = 5, SLL = 6, SRL = 7, SRA = 8, SLT = 9, SLTU = 10.

Any field that a requirement does not name takes its default: pc_src 0, wa_sel 0, a_sel 0, b_sel 0, wd_sel 1, alu_fn ADD, mem_we 0, rf_we 0.

- R1: While rst_req is 1, pc_src is 6 and both rf_we and mem_we are 0, whatever the other inputs are.
- R2: With rst_req 0 and irq 1, the vector is: pc_src 5, wa_sel 3, wd_sel 0, rf_we 1, mem_we 0. This holds for any instruction.
- R3: An opcode outside the supported set gives: pc_src 4, wa_sel 3, wd_sel 0, rf_we 1, mem_we 0. The same applies to an opcode 000000 word whose function code is outside the set.
- R4: Opcode 000000 with a function code in 100xxx or 10101x writes rd from the ALU (wa_sel 0, wd_sel 1, rf_we 1) with both operands from registers. The function mapping is:
  - 100000 and 100001 give ADD; 100010 and 100011 give SUB.
  - 100100, 100101, 100110 and 100111 give AND, OR, XOR and NOR.
  - 101010 gives SLT; 101011 gives SLTU.
- R5: Opcode 000000 with a function code in 000xxx, other than 000x01, is a shift writing rd from the ALU.
  - Bits 1:0 select the shift: 00 gives SLL, 10 gives SRL, 11 gives SRA.
  - Function bit 2 clear gives a_sel 1 (shamt); set gives a_sel 0 (rs).
  - b_sel is 0 in both cases.
- R6: Opcodes 001000 to 001110 write rt from the ALU (wa_sel 1, wd_sel 1, rf_we 1) with b_sel 1. The function mapping is:
  - 001000 and 001001 give ADD; 001010 gives SLT; 001011 gives SLTU.
  - 001100, 001101 and 001110 give AND, OR and XOR.
- R7: Opcode 001111 (load upper) gives a_sel 2, b_sel 1, alu_fn SLL, wa_sel 1, wd_sel 1, rf_we 1.
- R8: Opcode 100011 (load) gives alu_fn ADD, b_sel 1, wa_sel 1, wd_sel 2, rf_we 1. Opcode 101011 (store) gives alu_fn ADD, b_sel 1, mem_we 1, rf_we 0.
- R9: Opcodes 000100 and 000101 compare with alu_fn SUB and write nothing.
  - For 000100, pc_src is 1 when zero is 1, else 0.
  - For 000101, pc_src is 1 when zero is 0, else 0.
- R10: Opcodes 000010 and 000011 give pc_src 2. Opcode 000011 also writes r31 with PC+4 (wa_sel 2, wd_sel 0, rf_we 1).
- R11: Opcode 000000 with function 001000 or 001001 gives pc_src 3. Function 001001 also writes rd with PC+4 (wa_sel 0, wd_sel 0, rf_we 1).

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Current instruction word |
| zero | input | 1 | ALU result-is-zero flag for the compare |
| rst_req | input | 1 | Reset request, highest priority |
| irq | input | 1 | Interrupt request |
| pc_src | output | 3 | Next-PC source select |
| wa_sel | output | 2 | Register write-address source |
| a_sel | output | 2 | ALU operand A source |
| b_sel | output | 1 | ALU operand B source |
| wd_sel | output | 2 | Register write-data source |
| alu_fn | output | 4 | ALU function code |
| mem_we | output | 1 | Data-memory write enable |
| rf_we | output | 1 | Register-file write enable |

## Verification

The bench applies every primary opcode and, for opcode 000000, every function code, each with the zero flag both set and clear.

- The gaps between valid codes are therefore covered. A decoder that matched only a prefix would accept 000101 as a shift or 001010 as a register jump, and would then write a register instead of trapping.
- Sweeping the zero flag on both compare opcodes exposes an inverted not-equal branch.
- Interrupt and reset are raised on top of stores. A priority error there shows up as a memory write during a trap, or as a register write during reset.
- Load upper immediate and the two shift forms are compared field by field. An operand-A select that confuses shamt, 16 and register is therefore reported as a miscompare.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int OPC_W   = 6;
    localparam int FN_W    = 6;
    localparam int ALU_W   = 4;

    typedef enum logic [2:0] {
        PCS_SEQ     = 3'd0,
        PCS_BRANCH  = 3'd1,
        PCS_JUMP    = 3'd2,
        PCS_REG     = 3'd3,
        PCS_ILLEGAL = 3'd4,
        PCS_IRQ     = 3'd5,
        PCS_RESET   = 3'd6
    } pc_src_e;

    typedef enum logic [1:0] {
        WA_RD  = 2'd0,
        WA_RT  = 2'd1,
        WA_R31 = 2'd2,
        WA_R27 = 2'd3
    } wa_sel_e;

    typedef enum logic [1:0] {
        A_REG     = 2'd0,
        A_SHAMT   = 2'd1,
        A_SIXTEEN = 2'd2
    } a_sel_e;

    typedef enum logic {
        B_REG  = 1'b0,
        B_SEXT = 1'b1
    } b_sel_e;

    typedef enum logic [1:0] {
        WD_LINK = 2'd0,
        WD_ALU  = 2'd1,
        WD_MEM  = 2'd2
    } wd_sel_e;

    typedef enum logic [ALU_W-1:0] {
        ALU_ADD  = 4'd0,
        ALU_SUB  = 4'd1,
        ALU_AND  = 4'd2,
        ALU_OR   = 4'd3,
        ALU_XOR  = 4'd4,
        ALU_NOR  = 4'd5,
        ALU_SLL  = 4'd6,
        ALU_SRL  = 4'd7,
        ALU_SRA  = 4'd8,
        ALU_SLT  = 4'd9,
        ALU_SLTU = 4'd10
    } alu_fn_e;

    typedef enum logic [3:0] {
        IC_ALU_RR,
        IC_SHIFT,
        IC_ALU_IMM,
        IC_LUI,
        IC_LOAD,
        IC_STORE,
        IC_BRANCH,
        IC_JUMP,
        IC_JREG,
        IC_BAD
    } iclass_e;

    // Decoded form of one instruction before flag and trap handling.
    typedef struct packed {
        iclass_e cls;
        alu_fn_e alu;
        logic    var_shift;
        logic    link;
        logic    br_ne;
    } dec_t;

    // Full control vector presented to the datapath.
    typedef struct packed {
        pc_src_e pc_src;
        wa_sel_e wa;
        a_sel_e  a;
        b_sel_e  b;
        wd_sel_e wd;
        alu_fn_e alu;
        logic    mem_we;
        logic    rf_we;
    } ctl_t;

    localparam logic [OPC_W-1:0] OP_RFORM = 6'b000000;
    localparam logic [OPC_W-1:0] OP_LUI   = 6'b001111;
    localparam logic [OPC_W-1:0] OP_LOAD  = 6'b100011;
    localparam logic [OPC_W-1:0] OP_STORE = 6'b101011;

    function automatic ctl_t ctl_idle();
        ctl_t c;
        c.pc_src = PCS_SEQ;
        c.wa     = WA_RD;
        c.a      = A_REG;
        c.b      = B_REG;
        c.wd     = WD_ALU;
        c.alu    = ALU_ADD;
        c.mem_we = 1'b0;
        c.rf_we  = 1'b0;
        return c;
    endfunction

    // Low three function bits of register-form arithmetic/logic ops.
    function automatic alu_fn_e rr_alu(input logic [2:0] f3);
        case (f3)
            3'b000, 3'b001: return ALU_ADD;
            3'b010, 3'b011: return ALU_SUB;
            3'b100:         return ALU_AND;
            3'b101:         return ALU_OR;
            3'b110:         return ALU_XOR;
            default:        return ALU_NOR;
        endcase
    endfunction

    // Low three opcode bits of immediate-form ops.
    function automatic alu_fn_e imm_alu(input logic [2:0] o3);
        case (o3)
            3'b000, 3'b001: return ALU_ADD;
            3'b010:         return ALU_SLT;
            3'b011:         return ALU_SLTU;
            3'b100:         return ALU_AND;
            3'b101:         return ALU_OR;
            3'b110:         return ALU_XOR;
            default:        return ALU_SLL;
        endcase
    endfunction

    function automatic alu_fn_e shift_alu(input logic [1:0] kind);
        case (kind)
            2'b00:   return ALU_SLL;
            2'b10:   return ALU_SRL;
            default: return ALU_SRA;
        endcase
    endfunction

endpackage

// File: rtl/ctl_classify.sv
module ctl_classify
    import ctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    output dec_t             dec
);

    dec_t rform;
    dec_t top;

    // Register-form (opcode 000000) function decode.
    always_comb begin
        rform           = '0;
        rform.cls       = IC_BAD;
        rform.alu       = ALU_ADD;
        if (funct[5:3] == 3'b000 && funct[1:0] != 2'b01) begin
            rform.cls       = IC_SHIFT;
            rform.var_shift = funct[2];
            rform.alu       = shift_alu(funct[1:0]);
        end else if (funct[5:1] == 5'b00100) begin
            rform.cls  = IC_JREG;
            rform.link = funct[0];
        end else if (funct[5:3] == 3'b100) begin
            rform.cls = IC_ALU_RR;
            rform.alu = rr_alu(funct[2:0]);
        end else if (funct[5:1] == 5'b10101) begin
            rform.cls = IC_ALU_RR;
            rform.alu = funct[0] ? ALU_SLTU : ALU_SLT;
        end
    end

    // Primary opcode decode.
    always_comb begin
        top     = '0;
        top.cls = IC_BAD;
        top.alu = ALU_ADD;
        if (opcode == OP_RFORM) begin
            top = rform;
        end else if (opcode[5:1] == 5'b00001) begin
            top.cls  = IC_JUMP;
            top.link = opcode[0];
        end else if (opcode[5:1] == 5'b00010) begin
            top.cls   = IC_BRANCH;
            top.br_ne = opcode[0];
            top.alu   = ALU_SUB;
        end else if (opcode == OP_LUI) begin
            top.cls = IC_LUI;
            top.alu = ALU_SLL;
        end else if (opcode[5:3] == 3'b001) begin
            top.cls = IC_ALU_IMM;
            top.alu = imm_alu(opcode[2:0]);
        end else if (opcode == OP_LOAD) begin
            top.cls = IC_LOAD;
        end else if (opcode == OP_STORE) begin
            top.cls = IC_STORE;
        end
    end

    assign dec = top;

endmodule

// File: rtl/ctl_fields.sv
module ctl_fields
    import ctl_pkg::*;
(
    input  dec_t dec,
    input  logic zero,
    output ctl_t ctl
);

    always_comb begin
        ctl     = ctl_idle();
        ctl.alu = dec.alu;
        case (dec.cls)
            IC_ALU_RR: begin
                ctl.wa    = WA_RD;
                ctl.rf_we = 1'b1;
            end
            IC_SHIFT: begin
                ctl.wa    = WA_RD;
                ctl.a     = dec.var_shift ? A_REG : A_SHAMT;
                ctl.rf_we = 1'b1;
            end
            IC_ALU_IMM: begin
                ctl.wa    = WA_RT;
                ctl.b     = B_SEXT;
                ctl.rf_we = 1'b1;
            end
            IC_LUI: begin
                ctl.wa    = WA_RT;
                ctl.a     = A_SIXTEEN;
                ctl.b     = B_SEXT;
                ctl.rf_we = 1'b1;
            end
            IC_LOAD: begin
                ctl.wa    = WA_RT;
                ctl.b     = B_SEXT;
                ctl.wd    = WD_MEM;
                ctl.rf_we = 1'b1;
            end
            IC_STORE: begin
                ctl.b      = B_SEXT;
                ctl.mem_we = 1'b1;
            end
            IC_BRANCH: begin
                ctl.pc_src = (zero ^ dec.br_ne) ? PCS_BRANCH : PCS_SEQ;
            end
            IC_JUMP: begin
                ctl.pc_src = PCS_JUMP;
                if (dec.link) begin
                    ctl.wa    = WA_R31;
                    ctl.wd    = WD_LINK;
                    ctl.rf_we = 1'b1;
                end
            end
            IC_JREG: begin
                ctl.pc_src = PCS_REG;
                if (dec.link) begin
                    ctl.wa    = WA_RD;
                    ctl.wd    = WD_LINK;
                    ctl.rf_we = 1'b1;
                end
            end
            default: begin
                ctl = ctl_idle();
            end
        endcase
    end

endmodule

// File: rtl/ctl_trap.sv
module ctl_trap
    import ctl_pkg::*;
(
    input  ctl_t norm,
    input  logic bad,
    input  logic rst_req,
    input  logic irq,
    output ctl_t ctl
);

    // Priority: reset, then interrupt, then illegal instruction.
    always_comb begin
        ctl = norm;
        if (rst_req) begin
            ctl        = ctl_idle();
            ctl.pc_src = PCS_RESET;
        end else if (irq || bad) begin
            ctl        = ctl_idle();
            ctl.pc_src = irq ? PCS_IRQ : PCS_ILLEGAL;
            ctl.wa     = WA_R27;
            ctl.wd     = WD_LINK;
            ctl.rf_we  = 1'b1;
        end
    end

endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
    import ctl_pkg::*;
#(
    parameter int INSTR_W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               zero,
    input  logic               rst_req,
    input  logic               irq,
    output logic [2:0]         pc_src,
    output logic [1:0]         wa_sel,
    output logic [1:0]         a_sel,
    output logic               b_sel,
    output logic [1:0]         wd_sel,
    output logic [ALU_W-1:0]   alu_fn,
    output logic               mem_we,
    output logic               rf_we
);

    localparam int OPC_LSB = INSTR_W - OPC_W;

    dec_t dec;
    ctl_t norm;
    ctl_t fin;

    ctl_classify u_classify (
        .opcode (instr[INSTR_W-1:OPC_LSB]),
        .funct  (instr[FN_W-1:0]),
        .dec    (dec)
    );

    ctl_fields u_fields (
        .dec  (dec),
        .zero (zero),
        .ctl  (norm)
    );

    ctl_trap u_trap (
        .norm    (norm),
        .bad     (dec.cls == IC_BAD),
        .rst_req (rst_req),
        .irq     (irq),
        .ctl     (fin)
    );

    assign pc_src = fin.pc_src;
    assign wa_sel = fin.wa;
    assign a_sel  = fin.a;
    assign b_sel  = fin.b;
    assign wd_sel = fin.wd;
    assign alu_fn = fin.alu;
    assign mem_we = fin.mem_we;
    assign rf_we  = fin.rf_we;

endmodule

// File: rtl/ctl_decode_chk.sv
module ctl_decode_chk #(
    parameter int INSTR_W = 32
) (
    input logic [INSTR_W-1:0] instr,
    input logic               zero,
    input logic               rst_req,
    input logic               irq,
    input logic [2:0]         pc_src,
    input logic [1:0]         wa_sel,
    input logic [1:0]         a_sel,
    input logic               b_sel,
    input logic [1:0]         wd_sel,
    input logic [3:0]         alu_fn,
    input logic               mem_we,
    input logic               rf_we
);

    logic [5:0] op;
    assign op = instr[INSTR_W-1:INSTR_W-6];

    always_comb begin
        if (rst_req) begin
            a_r1_reset_quiet: assert (pc_src == 3'd6 && !rf_we && !mem_we)
                else $error("reset request still writes or redirects wrongly");
        end
        if (!rst_req && irq) begin
            a_r2_irq_link: assert (pc_src == 3'd5 && wa_sel == 2'd3 && rf_we && !mem_we)
                else $error("interrupt vector or link wrong");
        end
        if (pc_src == 3'd4) begin
            a_r3_trap_no_store: assert (!mem_we && wa_sel == 2'd3 && rf_we)
                else $error("illegal trap must link r27 and not store");
        end
        if (a_sel == 2'd2) begin
            a_r7_sixteen_only_lui: assert (op == 6'b001111 && alu_fn == 4'd6)
                else $error("constant-16 operand outside load upper");
        end
        if (mem_we) begin
            a_r8_store_only: assert (!rf_we && op == 6'b101011 && !rst_req && !irq)
                else $error("memory write outside a plain store");
        end
        if (pc_src == 3'd1) begin
            a_r9_branch_sense: assert (op[5:1] == 5'b00010 && (zero == !op[0]))
                else $error("branch taken with wrong flag sense");
        end
    end

endmodule

bind ctl_decode ctl_decode_chk #(.INSTR_W(INSTR_W)) u_chk (.*);

// File: tb/ctl_decode_bench.sv
module ctl_decode_bench;

    logic        clk = 1'b0;
    logic [31:0] instr = '0;
    logic        zero = 1'b0;
    logic        rst_req = 1'b0;
    logic        irq = 1'b0;
    logic [2:0]  pc_src;
    logic [1:0]  wa_sel;
    logic [1:0]  a_sel;
    logic        b_sel;
    logic [1:0]  wd_sel;
    logic [3:0]  alu_fn;
    logic        mem_we;
    logic        rf_we;

    int applied = 0;
    int bad     = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    ctl_decode u_ctl_decode (
        .instr   (instr),
        .zero    (zero),
        .rst_req (rst_req),
        .irq     (irq),
        .pc_src  (pc_src),
        .wa_sel  (wa_sel),
        .a_sel   (a_sel),
        .b_sel   (b_sel),
        .wd_sel  (wd_sel),
        .alu_fn  (alu_fn),
        .mem_we  (mem_we),
        .rf_we   (rf_we)
    );

    // Reference: returns {pc,wa,a,b,wd,alu,mw,rw} and the requirement it exercises.
    function automatic logic [15:0] model(input logic [31:0] w, input logic z,
                                          input logic rs, input logic ir,
                                          output string tag);
        int pc = 0, wa = 0, a = 0, b = 0, wd = 1, alu = 0, mw = 0, rw = 0;
        bit ok = 1'b1;
        int op = int'(w[31:26]);
        int fn = int'(w[5:0]);
        tag = "R3";
        if (op == 0) begin
            case (fn)
                0, 2, 3, 4, 6, 7: begin
                    tag = "R5"; wa = 0; wd = 1; rw = 1;
                    a = (fn >= 4) ? 0 : 1;
                    alu = ((fn % 4) == 0) ? 6 : ((fn % 4) == 2) ? 7 : 8;
                end
                8:  begin tag = "R11"; pc = 3; end
                9:  begin tag = "R11"; pc = 3; wa = 0; wd = 0; rw = 1; end
                32, 33: begin tag = "R4"; rw = 1; alu = 0; end
                34, 35: begin tag = "R4"; rw = 1; alu = 1; end
                36: begin tag = "R4"; rw = 1; alu = 2; end
                37: begin tag = "R4"; rw = 1; alu = 3; end
                38: begin tag = "R4"; rw = 1; alu = 4; end
                39: begin tag = "R4"; rw = 1; alu = 5; end
                42: begin tag = "R4"; rw = 1; alu = 9; end
                43: begin tag = "R4"; rw = 1; alu = 10; end
                default: ok = 1'b0;
            endcase
        end else begin
            case (op)
                2:  begin tag = "R10"; pc = 2; end
                3:  begin tag = "R10"; pc = 2; wa = 2; wd = 0; rw = 1; end
                4:  begin tag = "R9"; alu = 1; pc = z ? 1 : 0; end
                5:  begin tag = "R9"; alu = 1; pc = z ? 0 : 1; end
                8, 9:   begin tag = "R6"; wa = 1; b = 1; rw = 1; alu = 0; end
                10: begin tag = "R6"; wa = 1; b = 1; rw = 1; alu = 9; end
                11: begin tag = "R6"; wa = 1; b = 1; rw = 1; alu = 10; end
                12: begin tag = "R6"; wa = 1; b = 1; rw = 1; alu = 2; end
                13: begin tag = "R6"; wa = 1; b = 1; rw = 1; alu = 3; end
                14: begin tag = "R6"; wa = 1; b = 1; rw = 1; alu = 4; end
                15: begin tag = "R7"; wa = 1; a = 2; b = 1; rw = 1; alu = 6; end
                35: begin tag = "R8"; wa = 1; b = 1; wd = 2; rw = 1; end
                43: begin tag = "R8"; b = 1; mw = 1; end
                default: ok = 1'b0;
            endcase
        end
        if (rs || ir || !ok) begin
            wa = 0; a = 0; b = 0; wd = 1; alu = 0; mw = 0; rw = 0; pc = 0;
            if (rs) begin
                tag = "R1"; pc = 6;
            end else begin
                tag = ir ? "R2" : "R3";
                pc = ir ? 5 : 4; wa = 3; wd = 0; rw = 1;
            end
        end
        return {pc[2:0], wa[1:0], a[1:0], b[0], wd[1:0], alu[3:0], mw[0], rw[0]};
    endfunction

    task automatic apply(input logic [31:0] w, input logic z, input logic rs, input logic ir);
        logic [15:0] exp_v;
        logic [15:0] got;
        string tag;
        @(posedge clk);
        instr = w; zero = z; rst_req = rs; irq = ir;
        @(negedge clk);
        exp_v = model(w, z, rs, ir, tag);
        got = {pc_src, wa_sel, a_sel, b_sel, wd_sel, alu_fn, mem_we, rf_we};
        applied++;
        if (got !== exp_v) begin
            bad++;
            $display("FAIL %s instr=%h z=%0b rst=%0b irq=%0b actual=%h expected=%h",
                     tag, w, z, rs, ir, got, exp_v);
        end
    endtask

    function automatic logic [31:0] mk(input int op, input int fn, input int k);
        logic [19:0] mid = 20'hA5C3F ^ 20'(k * 7919);
        return {op[5:0], mid, fn[5:0]};
    endfunction

    initial begin
        // R1: reset state with a store on the bus
        apply(mk(43, 0, 1), 1'b0, 1'b1, 1'b0);
        // R4/R5/R11/R3: every function code in register form, both flag values
        for (int f = 0; f < 64; f++) begin
            for (int z = 0; z < 2; z++) apply(mk(0, f, f), z[0], 1'b0, 1'b0);
        end
        // R6..R10/R3: every other opcode, both flag values
        for (int o = 1; o < 64; o++) begin
            for (int z = 0; z < 2; z++) apply(mk(o, o ^ 21, o), z[0], 1'b0, 1'b0);
        end
        // R2 and R1 override any instruction, including stores and illegal words
        for (int o = 0; o < 64; o++) begin
            apply(mk(o, 32, o), 1'b1, 1'b0, 1'b1);
            apply(mk(o, 9, o), 1'b0, 1'b1, 1'b0);
            apply(mk(o, 43, o), 1'b1, 1'b1, 1'b1);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

endmodule